// File: doc/BRIEF.md
# Display Controller Interrupt Unit

This unit gathers single-cycle event pulses raised by a display controller's raster and DMA logic and turns them into one interrupt line for a host processor. Each event type latches into its own sticky bit of a raw status word. A separate enable mask selects which events may interrupt, and the masked status shows the latched events that pass that mask.

Software reaches the unit through a plain word-addressed register port with a write strobe and a combinational read path. Enable bits are never written directly: one address sets bits and another clears them, so two agents can edit different bits without a read-modify-write race. Status bits are acknowledged by writing ones to the masked-status address. After the interrupt line pulses, the unit stays disarmed until software writes the end-of-interrupt address, so a burst of events produces a single notification per service pass.

Top module: `dispctl_irq_unit`

## Requirements
- R1: After reset the raw status and enable mask read as zero, the unit is armed and `irq_o` is low.
- R2: An event pulse on `evt_i[k]` latches status bit k at offset 0x0. The implemented bits are frame done 0, raster done 1, sync lost 2, AC-bias count 3, FIFO underflow 5, palette loaded 6, end-of-frame buffer 0 at 8 and end-of-frame buffer 1 at 9. Bits 4, 7 and 10 and above always read zero.
- R3: Reading offset 0x4 returns the raw status ANDed with the enable mask.
- R4: A write to offset 0x8 sets every enable bit whose data bit is one. Zero data bits leave the mask unchanged.
- R5: A write to offset 0xC clears every enable bit whose data bit is one. Zero data bits leave the mask unchanged.
- R6: A write to offset 0x4 clears every status bit whose data bit is one, and zero bits leave status unchanged. Writes to offset 0x0 have no effect.
- R7: When an event and a status clear hit the same bit in one cycle, the bit remains set.
- R8: While armed, a nonzero masked status raises `irq_o` for exactly one cycle, two clock edges after the event is sampled, or after the enabling write. Raising it disarms the unit.
- R9: While disarmed, `irq_o` stays low. A write of any value to offset 0x10 re-arms the unit, and any masked status still pending then raises `irq_o` again. An end-of-interrupt write that lands in the same cycle as a firing is dropped.
- R10: Reading offset 0x8 or offset 0xC returns the current enable mask. Offset 0x10 and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | EVT_W (10) | Event pulses, one bit per event type |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (5) | Byte address of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Single-cycle interrupt pulse |

## Verification
On every cycle, assertions check that a sampled event is latched even against a simultaneous clear, and that set bits survive unless cleared. They also check that set and clear writes land on the enable mask, that the interrupt is a one-cycle pulse leaving the unit disarmed, and that arming only follows an end-of-interrupt write. The bench scenarios are the only place where the address map, the read values of unimplemented bits, the ignored raw-status write, the exact two-edge interrupt latency and the re-fire after end-of-interrupt can be observed.

// File: rtl/dispctl_irq_pkg.sv
package dispctl_irq_pkg;
  localparam int EVT_W = 10;

  localparam int BIT_FRAME_DONE  = 0;
  localparam int BIT_RASTER_DONE = 1;
  localparam int BIT_SYNC_LOST   = 2;
  localparam int BIT_ACB_COUNT   = 3;
  localparam int BIT_FIFO_UFLOW  = 5;
  localparam int BIT_PAL_LOADED  = 6;
  localparam int BIT_EOF_BUF0    = 8;
  localparam int BIT_EOF_BUF1    = 9;

  localparam logic [EVT_W-1:0] IMPL_MASK =
      EVT_W'((1 << BIT_FRAME_DONE) | (1 << BIT_RASTER_DONE) |
             (1 << BIT_SYNC_LOST)  | (1 << BIT_ACB_COUNT)   |
             (1 << BIT_FIFO_UFLOW) | (1 << BIT_PAL_LOADED)  |
             (1 << BIT_EOF_BUF0)   | (1 << BIT_EOF_BUF1));

  localparam int OFS_RAW    = 'h00;
  localparam int OFS_MASKED = 'h04;
  localparam int OFS_EN_SET = 'h08;
  localparam int OFS_EN_CLR = 'h0C;
  localparam int OFS_EOI    = 'h10;
endpackage

// File: rtl/dispctl_irq_status.sv
module dispctl_irq_status
  import dispctl_irq_pkg::*;
#(
  parameter int W = EVT_W,
  parameter logic [W-1:0] IMPL = IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] raw_q;

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (IMPL[k]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          raw_q[k] <= 1'b0;
        else if (evt_i[k])   raw_q[k] <= 1'b1;
        else if (clr_i[k])   raw_q[k] <= 1'b0;
      end

      // R7
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[k] |=> raw_q[k]);

      // R6
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[k] && !clr_i[k]) |=> raw_q[k]);
    end else begin : g_none
      assign raw_q[k] = 1'b0;
    end
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/dispctl_irq_enable.sv
module dispctl_irq_enable
  import dispctl_irq_pkg::*;
#(
  parameter int W = EVT_W,
  parameter logic [W-1:0] IMPL = IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] sel;

  assign sel = bits_i & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (set_i) en_q <= en_q | sel;
    else if (clr_i) en_q <= en_q & ~sel;
  end

  assign en_o = en_q;

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((en_q & $past(sel)) == $past(sel)));

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> ((en_q & $past(sel)) == '0));
endmodule

// File: rtl/dispctl_irq_arm.sv
module dispctl_irq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic armed_q;
  logic irq_q;
  logic fire;

  assign fire = armed_q & pending_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire;
      if (fire)       armed_q <= 1'b0;
      else if (eoi_i) armed_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R8
  irq_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !armed_q);

  // R9
  stay_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !eoi_i) |=> !armed_q);
endmodule

// File: rtl/dispctl_irq_unit.sv
module dispctl_irq_unit
  import dispctl_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - EVT_W;

  logic             hit_raw, hit_masked, hit_set, hit_clr, hit_eoi;
  logic [EVT_W-1:0] wbits;
  logic [EVT_W-1:0] raw, en, masked;
  logic [EVT_W-1:0] rd_sel;

  assign hit_raw    = (addr_i == ADDR_W'(OFS_RAW));
  assign hit_masked = (addr_i == ADDR_W'(OFS_MASKED));
  assign hit_set    = (addr_i == ADDR_W'(OFS_EN_SET));
  assign hit_clr    = (addr_i == ADDR_W'(OFS_EN_CLR));
  assign hit_eoi    = (addr_i == ADDR_W'(OFS_EOI));
  assign wbits      = wdata_i[EVT_W-1:0];

  dispctl_irq_status #(.W(EVT_W), .IMPL(IMPL_MASK)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i & IMPL_MASK),
    .clr_i ((wr_en_i && hit_masked) ? wbits : '0),
    .raw_o (raw)
  );

  dispctl_irq_enable #(.W(EVT_W), .IMPL(IMPL_MASK)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wr_en_i && hit_set),
    .clr_i  (wr_en_i && hit_clr),
    .bits_i (wbits),
    .en_o   (en)
  );

  assign masked = raw & en;

  dispctl_irq_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (|masked),
    .eoi_i     (wr_en_i && hit_eoi),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_sel = '0;
    if (hit_raw)               rd_sel = raw;
    else if (hit_masked)       rd_sel = masked;
    else if (hit_set | hit_clr) rd_sel = en;
  end

  assign rdata_o = {{PAD_W{1'b0}}, rd_sel};
endmodule

// File: tb/dispctl_irq_unit_bench.sv
module dispctl_irq_unit_bench;
  localparam int EW = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_EV = 2'd2;
  localparam int NV = 19;
  // {op, req, addr, data/expect}
  localparam logic [2+4+AW+DW-1:0] VEC [NV] = '{
    {OP_EV, 4'd2,  5'h00, 32'h0000_03FF},
    {OP_RD, 4'd2,  5'h00, 32'h0000_036F},
    {OP_RD, 4'd3,  5'h04, 32'h0000_0000},
    {OP_WR, 4'd4,  5'h08, 32'hFFFF_FFFF},
    {OP_RD, 4'd4,  5'h08, 32'h0000_036F},
    {OP_RD, 4'd10, 5'h0C, 32'h0000_036F},
    {OP_WR, 4'd5,  5'h0C, 32'h0000_0101},
    {OP_RD, 4'd5,  5'h08, 32'h0000_026E},
    {OP_RD, 4'd3,  5'h04, 32'h0000_026E},
    {OP_WR, 4'd6,  5'h04, 32'h0000_0022},
    {OP_RD, 4'd6,  5'h00, 32'h0000_034D},
    {OP_RD, 4'd3,  5'h04, 32'h0000_024C},
    {OP_WR, 4'd6,  5'h00, 32'hFFFF_FFFF},
    {OP_RD, 4'd6,  5'h00, 32'h0000_034D},
    {OP_WR, 4'd4,  5'h08, 32'h0000_0000},
    {OP_RD, 4'd4,  5'h08, 32'h0000_026E},
    {OP_WR, 4'd5,  5'h0C, 32'h0000_0000},
    {OP_RD, 4'd5,  5'h0C, 32'h0000_026E},
    {OP_RD, 4'd10, 5'h10, 32'h0000_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [EW-1:0] evt = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dispctl_irq_unit u_dispctl_irq_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  function automatic string tag(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req,
                    input logic [DW-1:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic ev(input logic [EW-1:0] m);
    @(negedge clk);
    evt = m;
    @(posedge clk);
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1", {31'b0, irq}, 32'h0);
    rd(5'h00, "R1", 32'h0);
    rd(5'h08, "R1", 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]    op;
      logic [3:0]    rq;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      {op, rq, a, d} = VEC[i];
      case (op)
        OP_WR: wr(a, d);
        OP_RD: rd(a, tag(int'(rq)), d);
        default: ev(d[EW-1:0]);
      endcase
    end

    // return to a clean, armed state
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0);
    rd(5'h00, "R6", 32'h0);

    // R7 event and clear on the same bit in one cycle
    @(negedge clk);
    evt = 10'h004; wr_en = 1'b1; addr = 5'h04; wdata = 32'h4;
    @(posedge clk);
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wdata = '0;
    rd(5'h00, "R7", 32'h4);

    // R8 enabling a pending bit fires once, two edges after the write
    @(negedge clk);
    wr_en = 1'b1; addr = 5'h08; wdata = 32'h4;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    check("R8", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R8", {31'b0, irq}, 32'h0);

    // R9 no interrupt while disarmed, even for a new enabled event
    wr(5'h08, 32'h1);
    ev(10'h001);
    begin
      logic seen = 1'b0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (irq) seen = 1'b1;
      end
      check("R9", {31'b0, seen}, 32'h0);
    end
    rd(5'h04, "R3", 32'h5);

    // R9 end-of-interrupt write of arbitrary data re-fires on pending status
    @(negedge clk);
    wr_en = 1'b1; addr = 5'h10; wdata = 32'h1234_5678;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    check("R9", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R9", {31'b0, irq}, 32'h0);

    // R2 unimplemented event lines never latch
    ev(10'h090);
    rd(5'h00, "R2", 32'h5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule